// File: doc/BRIEF.md
# Blanking-Interval Copy-Control and Aspect Data Inserter

This block writes two kinds of low-rate control data into one line of the vertical blanking interval of a standard-definition digital luma stream. The first is a 20-bit copy-generation word, sent only when the stream is set to NTSC. The second is a 14-bit widescreen word, sent only when the stream is set to PAL. On the line chosen for a format, the block stops passing the incoming samples through. A fixed number of samples after the line start, it drives a run of equal-width bit cells. Each cell holds a programmable high code for a one and the blanking code for a zero.

The copy-generation word is led by a reference cell that is always high and is as wide as a data bit. Two enable inputs pick whether that word goes out on odd fields, on even fields, or on both. The widescreen word has one enable and goes out on line 23. Both words are sent least-significant bit first.

The line number, field, standard select, enables and payload words are all sampled in the cycle that marks the start of a line. Later changes to these inputs within that line have no effect on the line. Every output sample is registered, so each input sample leaves the block one clock later.

Top module: `vbi_cp_inserter`

## Requirements
- R1: While reset is asserted, `video_out` is 0.
- R2: Outside an insertion window, `video_out` equals the `video_in` value of the previous clock cycle (one cycle of latency).
- R3: On an NTSC line whose number equals `CG_LINE` (default 20), when the field's enable is set, samples `OFFSET` up to `OFFSET+BITW-1` are counted from the line-start sample, which is sample 0. These samples form a reference cell driven with `high_code`.
- R4: After the reference cell come 20 copy-generation cells of `BITW` samples each. Cell k carries `cg_word[k]`, with bit 0 first. A 1 drives `high_code` and a 0 drives `blank_code`.
- R5: On an odd field (`field_odd`=1), copy-generation data is sent only if `cg_en_odd`=1. On an even field it is sent only if `cg_en_even`=1. Otherwise the line passes through unchanged.
- R6: When `std_pal`=1, no copy-generation data is inserted on any line.
- R7: When `std_pal`=1, `ws_en`=1 and the line number is `WS_LINE` (default 23), 14 cells carry `ws_word[0]` through `ws_word[13]` in that order, starting at sample `OFFSET`. With `std_pal`=0, no widescreen data is inserted.
- R8: The line number, field, standard, enables and payload words are captured only on the cycle where `line_start`=1. Changes to them later in the line do not alter the line's output.
- R9: After the last cell of a word, the line returns to pass-through until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | High on the first sample of each line |
| line_num | input | LW | Line number within the current field |
| field_odd | input | 1 | 1 for an odd field, 0 for an even field |
| std_pal | input | 1 | Standard select: 0 NTSC, 1 PAL |
| cg_en_odd | input | 1 | Copy-generation enable for odd fields |
| cg_en_even | input | 1 | Copy-generation enable for even fields |
| ws_en | input | 1 | Widescreen enable |
| cg_word | input | 20 | Copy-generation payload |
| ws_word | input | 14 | Widescreen payload |
| high_code | input | DW | Sample code for a logic 1 and for the reference cell |
| blank_code | input | DW | Sample code for a logic 0 |
| video_in | input | DW | Incoming luma sample |
| video_out | output | DW | Luma sample with the inserted data |

## Verification
Each output sample is due exactly one clock after the sample it belongs to. The bench drives a sample just after a falling edge and reads `video_out` shortly after the next rising edge. It compares that value with a model that counts samples from the line start and finds the cell index by division. The capture at line start takes effect at once for that line. Because `OFFSET` is at least one, the bench latches its own copy of the decoded format and payload on the same cycle. It then perturbs the live inputs partway through a line. The cell boundaries, the first pass-through sample after the last cell, and the field and standard gates are all covered, both by directed lines and by seeded random lines.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int CG_BITS = 20;
  localparam int WS_BITS = 14;
  localparam int SLOT_W  = $clog2(CG_BITS + 2);

  typedef enum logic [1:0] {INS_NONE = 2'd0, INS_CG = 2'd1, INS_WS = 2'd2} ins_kind_t;

  // Number of bit cells sent for a format (reference cell included).
  function automatic logic [SLOT_W-1:0] slot_count(input ins_kind_t kind);
    case (kind)
      INS_CG:  slot_count = SLOT_W'(CG_BITS + 1);
      INS_WS:  slot_count = SLOT_W'(WS_BITS);
      default: slot_count = '0;
    endcase
  endfunction

  // Logic level carried by a given cell.
  function automatic logic slot_level(input ins_kind_t kind, input logic [SLOT_W-1:0] slot,
                                      input logic [CG_BITS-1:0] cg, input logic [WS_BITS-1:0] ws);
    logic [SLOT_W-1:0] idx;
    slot_level = 1'b0;
    idx = slot - 1'b1;
    if (kind == INS_CG) begin
      if (slot == '0) slot_level = 1'b1;
      else            slot_level = cg[idx];
    end else if (kind == INS_WS) begin
      if (slot < SLOT_W'(WS_BITS)) slot_level = ws[slot[3:0]];
    end
  endfunction
endpackage

// File: rtl/vbi_field_gate.sv
module vbi_field_gate
  import vbi_pkg::*;
#(
  parameter int LW      = 10,
  parameter int CG_LINE = 20,
  parameter int WS_LINE = 23
) (
  input  logic [LW-1:0] line_num,
  input  logic          field_odd,
  input  logic          std_pal,
  input  logic          cg_en_odd,
  input  logic          cg_en_even,
  input  logic          ws_en,
  output ins_kind_t     kind
);
  localparam logic [LW-1:0] CG_L = LW'(CG_LINE);
  localparam logic [LW-1:0] WS_L = LW'(WS_LINE);

  logic field_ok;
  assign field_ok = field_odd ? cg_en_odd : cg_en_even;

  always_comb begin
    kind = INS_NONE;
    if (!std_pal && line_num == CG_L && field_ok) kind = INS_CG;
    else if (std_pal && line_num == WS_L && ws_en) kind = INS_WS;
  end
endmodule

// File: rtl/vbi_line_latch.sv
module vbi_line_latch
  import vbi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  ins_kind_t          kind_in,
  input  logic [CG_BITS-1:0] cg_in,
  input  logic [WS_BITS-1:0] ws_in,
  output ins_kind_t          kind_q,
  output logic [CG_BITS-1:0] cg_q,
  output logic [WS_BITS-1:0] ws_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= INS_NONE;
      cg_q   <= '0;
      ws_q   <= '0;
    end else if (line_start) begin
      kind_q <= kind_in;
      cg_q   <= cg_in;
      ws_q   <= ws_in;
    end
  end
endmodule

// File: rtl/vbi_slot_timer.sv
module vbi_slot_timer
  import vbi_pkg::*;
#(
  parameter int OFFSET = 16,
  parameter int BITW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [SLOT_W-1:0] nslots,
  output logic              in_win,
  output logic [SLOT_W-1:0] slot
);
  localparam int OW = $clog2(OFFSET + 1);
  localparam int PW = (BITW > 1) ? $clog2(BITW) : 1;
  localparam logic [OW-1:0] LEAD_END = OW'(OFFSET);
  localparam logic [PW-1:0] PH_END   = PW'(BITW - 1);

  logic [OW-1:0]     lead_q, lead_cur;
  logic [PW-1:0]     ph_q;
  logic [SLOT_W-1:0] slot_q;
  logic              lead_done;

  assign lead_cur  = line_start ? '0 : lead_q;
  assign lead_done = (lead_cur == LEAD_END);
  assign in_win    = lead_done && (slot_q < nslots);
  assign slot      = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= LEAD_END;
      ph_q   <= '0;
      slot_q <= '0;
    end else begin
      lead_q <= lead_done ? lead_cur : lead_cur + 1'b1;
      if (line_start) begin
        ph_q   <= '0;
        slot_q <= '0;
      end else if (in_win) begin
        if (ph_q == PH_END) begin
          ph_q   <= '0;
          slot_q <= slot_q + 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vbi_cp_inserter.sv
module vbi_cp_inserter
  import vbi_pkg::*;
#(
  parameter int DW      = 10,
  parameter int LW      = 10,
  parameter int OFFSET  = 16,
  parameter int BITW    = 8,
  parameter int CG_LINE = 20,
  parameter int WS_LINE = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [LW-1:0] line_num,
  input  logic          field_odd,
  input  logic          std_pal,
  input  logic          cg_en_odd,
  input  logic          cg_en_even,
  input  logic          ws_en,
  input  logic [19:0]   cg_word,
  input  logic [13:0]   ws_word,
  input  logic [DW-1:0] high_code,
  input  logic [DW-1:0] blank_code,
  input  logic [DW-1:0] video_in,
  output logic [DW-1:0] video_out
);
  ins_kind_t          kind_d, kind_q;
  logic [CG_BITS-1:0] cg_q;
  logic [WS_BITS-1:0] ws_q;
  logic [SLOT_W-1:0]  nslots, slot;
  logic               in_win, level;

  vbi_field_gate #(.LW(LW), .CG_LINE(CG_LINE), .WS_LINE(WS_LINE)) u_gate (
    .line_num(line_num), .field_odd(field_odd), .std_pal(std_pal),
    .cg_en_odd(cg_en_odd), .cg_en_even(cg_en_even), .ws_en(ws_en), .kind(kind_d));

  vbi_line_latch u_latch (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .kind_in(kind_d),
    .cg_in(cg_word), .ws_in(ws_word), .kind_q(kind_q), .cg_q(cg_q), .ws_q(ws_q));

  assign nslots = slot_count(kind_q);

  vbi_slot_timer #(.OFFSET(OFFSET), .BITW(BITW)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .nslots(nslots),
    .in_win(in_win), .slot(slot));

  assign level = slot_level(kind_q, slot, cg_q, ws_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      video_out <= '0;
    else if (in_win) video_out <= level ? high_code : blank_code;
    else             video_out <= video_in;
  end
endmodule

// File: rtl/vbi_cp_checker.sv
module vbi_cp_checker
  import vbi_pkg::*;
#(
  parameter int DW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              std_pal,
  input logic [DW-1:0]     video_in,
  input logic [DW-1:0]     high_code,
  input logic [DW-1:0]     blank_code,
  input logic [DW-1:0]     video_out,
  input logic              in_win,
  input ins_kind_t         kind_q,
  input logic [SLOT_W-1:0] slot,
  input logic [CG_BITS-1:0] cg_q,
  input logic [WS_BITS-1:0] ws_q
);
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> video_out == $past(video_in));

  assert_ref_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && kind_q == INS_CG && slot == '0) |=> video_out == $past(high_code));

  assert_two_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |=> (video_out == $past(high_code)) || (video_out == $past(blank_code)));

  assert_no_cg_pal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && std_pal) |=> kind_q != INS_CG);

  assert_no_ws_ntsc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !std_pal) |=> kind_q != INS_WS);

  assert_payload_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(cg_q) && $stable(ws_q) && $stable(kind_q)));

  assert_slot_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> ((slot == $past(slot) + 1'b1) || (slot == '0)));
endmodule

bind vbi_cp_inserter vbi_cp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .std_pal(std_pal),
  .video_in(video_in), .high_code(high_code), .blank_code(blank_code),
  .video_out(video_out), .in_win(in_win), .kind_q(kind_q), .slot(slot),
  .cg_q(cg_q), .ws_q(ws_q));

// File: tb/vbi_cp_inserter_test.sv
`timescale 1ns/1ps
module vbi_cp_inserter_test;
  localparam int DW = 10, LW = 10, OFF = 16, BW = 8, CGL = 20, WSL = 23;
  localparam int LINE_LEN = OFF + 21 * BW + 16;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic field_odd = 1'b0, std_pal = 1'b0, cg_en_odd = 1'b0, cg_en_even = 1'b0, ws_en = 1'b0;
  logic [19:0] cg_word = '0;
  logic [13:0] ws_word = '0;
  logic [DW-1:0] high_code = '0, blank_code = '0, video_in = '0, video_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vbi_cp_inserter #(.DW(DW), .LW(LW), .OFFSET(OFF), .BITW(BW), .CG_LINE(CGL), .WS_LINE(WSL)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .field_odd(field_odd), .std_pal(std_pal), .cg_en_odd(cg_en_odd), .cg_en_even(cg_en_even),
    .ws_en(ws_en), .cg_word(cg_word), .ws_word(ws_word), .high_code(high_code),
    .blank_code(blank_code), .video_in(video_in), .video_out(video_out));

  // 0 none, 1 copy-generation, 2 widescreen
  function automatic int decode(int ln, bit odd, bit pal, bit eo, bit ee, bit we);
    if (!pal && ln == CGL && (odd ? eo : ee)) return 1;
    if (pal && ln == WSL && we) return 2;
    return 0;
  endfunction

  function automatic int ncells(int kind);
    return (kind == 1) ? 21 : (kind == 2) ? 14 : 0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_line(int ln, bit odd, bit pal, bit eo, bit ee, bit we,
                          logic [19:0] cg, logic [13:0] ws, bit mutate, string tag);
    int kind;
    logic [19:0] lcg;
    logic [13:0] lws;
    logic [DW-1:0] hi, bl, exp;
    string t;
    hi = DW'($urandom_range(512, 1023));
    bl = DW'($urandom_range(0, 255));
    kind = decode(ln, odd, pal, eo, ee, we);
    lcg = cg; lws = ws;
    for (int s = 0; s < LINE_LEN; s++) begin
      @(negedge clk);
      line_start = (s == 0);
      video_in   = DW'($urandom);
      high_code  = hi;
      blank_code = bl;
      if (s == 0) begin
        line_num = LW'(ln); field_odd = odd; std_pal = pal;
        cg_en_odd = eo; cg_en_even = ee; ws_en = we;
        cg_word = cg; ws_word = ws;
      end else if (mutate && s == OFF + 3 * BW) begin
        line_num = LW'($urandom_range(0, 30)); field_odd = ~field_odd; std_pal = ~std_pal;
        cg_en_odd = ~cg_en_odd; cg_en_even = ~cg_en_even; ws_en = ~ws_en;
        cg_word = ~cg_word; ws_word = ~ws_word;
      end
      t = tag;
      if (kind != 0 && s >= OFF && s < OFF + ncells(kind) * BW) begin
        int k;
        bit lvl;
        k = (s - OFF) / BW;
        if (kind == 1) lvl = (k == 0) ? 1'b1 : lcg[k-1];
        else           lvl = lws[k];
        exp = lvl ? hi : bl;
        if (!mutate) t = (kind == 2) ? "R7" : (k == 0) ? "R3" : "R4";
      end else begin
        exp = video_in;
        if (kind != 0 && s >= OFF && !mutate) t = "R9";
      end
      @(posedge clk);
      #1;
      check(t, video_out, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    video_in = 10'h2AB;
    repeat (3) @(negedge clk);
    check("R1", video_out, '0);
    @(posedge clk); #1;
    check("R1", video_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    run_line(5, 1, 0, 1, 1, 1, 20'hA5C3F, 14'h1234, 0, "R2");
    run_line(CGL, 1, 0, 1, 0, 0, 20'hA5C3F, 14'h0, 0, "R3");
    run_line(CGL, 1, 0, 1, 0, 0, 20'hFFFFF, 14'h0, 0, "R4");
    run_line(CGL, 1, 0, 1, 0, 0, 20'h00000, 14'h0, 0, "R4");
    run_line(CGL, 0, 0, 1, 0, 0, 20'h5A5A5, 14'h0, 0, "R5");
    run_line(CGL, 0, 0, 0, 1, 0, 20'h5A5A5, 14'h0, 0, "R5");
    run_line(CGL, 1, 0, 0, 1, 0, 20'h5A5A5, 14'h0, 0, "R5");
    run_line(CGL, 1, 1, 1, 1, 1, 20'hFFFFF, 14'h3FFF, 0, "R6");
    run_line(WSL, 1, 1, 0, 0, 1, 20'h0, 14'h2C71, 0, "R7");
    run_line(WSL, 0, 0, 1, 1, 1, 20'hFFFFF, 14'h3FFF, 0, "R7");
    run_line(CGL, 1, 0, 1, 1, 0, 20'h80001, 14'h0, 1, "R8");
    run_line(WSL, 0, 1, 0, 0, 1, 20'h0, 14'h2001, 1, "R8");
    run_line(CGL, 0, 0, 0, 0, 1, 20'hFFFFF, 14'h3FFF, 1, "R8");

    for (int i = 0; i < 40; i++) begin
      int ln;
      int pick;
      pick = $urandom_range(0, 3);
      ln = (pick == 0) ? CGL : (pick == 1) ? WSL : $urandom_range(0, 40);
      run_line(ln, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               20'($urandom), 14'($urandom), 1'($urandom), "R2");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule